// File: doc/BRIEF.md
# Gated Slave FIFO Port

This block is the external-facing side of a set of four endpoint FIFOs. An outside controller picks a FIFO with a two-bit select and then moves data through a 16-bit bus. The bus has separate inbound and outbound halves plus a per-bit drive enable. All of its control inputs pass through an active-low chip select: the write strobe, the read strobe, the output enable and a packet-end marker. When the chip select is high, none of them reaches the FIFOs or the bus drivers.

The port has two timing modes. In synchronous mode each strobe is a level qualifier: every rising clock edge that sees it high moves one word. In asynchronous mode each strobe is a free-running pulse. The pulse is resynchronised into the clock domain, and exactly one transfer happens per falling edge, however long the pulse was high. Each FIFO has its own configuration bit that selects byte or word transfers, and the bus drivers follow the width of the FIFO currently addressed.

Every FIFO also counts words into packets. A packet is complete when it reaches the maximum size, or earlier when packet-end is given. A per-FIFO flag shows that a completed packet is waiting. Writing while output enable is active is reported as a bus conflict. A write to a full FIFO or a read from an empty FIFO is dropped and recorded in a sticky error bit. The port carries no valid/ready handshake: flow control is left to the external master, which watches the empty and full flags.

Top module: `slv_fifo_port`

## Requirements
- R1: After reset, every FIFO is empty and none is full. No packet flag is set, both error bits are clear, and the data bus is not driven (drive enable 16'h0000).
- R2: `fifo_sel` picks FIFO 0 to 3. Each FIFO returns its own words first-in first-out, independent of the others. `data_out` shows the head word of the selected FIFO before the read that removes it. No FIFO is ever empty and full at once.
- R3: With `sel_n` high, `wr`, `rd`, `oe` and `pkt_end` change nothing: no word is stored or removed, no packet is committed and the bus is not driven.
- R4: `wide_cfg[i]` = 1 makes FIFO i word-wide and 0 makes it byte-wide. A byte-wide FIFO keeps only `data_in[7:0]` and returns it with the upper byte as zero. With `sel_n` low, `oe` high and `wr` low, `data_oe` is 16'hFFFF for a word-wide FIFO and 16'h00FF for a byte-wide one.
- R5: With `async_mode` = 0, a write or read strobe held high for N clock cycles moves N words, one per rising edge.
- R6: With `async_mode` = 1, each high-to-low transition of a chip-selected strobe moves exactly one word, however long the strobe was high. The transfer takes effect by the third rising edge after the fall.
- R7: `conflict` is high whenever `sel_n` is low and `wr` and `oe` are both high. While it is high, `data_oe` is 16'h0000.
- R8: A FIFO holding DEPTH (8) words raises `full`. A further write is dropped, leaves the stored data unchanged and sets `ovf_err` until the next reset.
- R9: A read from an empty FIFO removes nothing and sets `unf_err` until the next reset.
- R10: `pkt_avail[i]` rises once FIFO i has taken PKT_WORDS (4) words since its last commit, or when `pkt_end` arrives while some words are uncommitted. It falls when the FIFO becomes empty. A `pkt_end` with no uncommitted words sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, at most 48 MHz in a system |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low chip select that gates all four controls |
| fifo_sel | input | 2 | Index of the FIFO being addressed |
| async_mode | input | 1 | 0: strobes are clock qualifiers, 1: strobes are edge pulses |
| wide_cfg | input | 4 | Per-FIFO width, 1 word, 0 byte |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| oe | input | 1 | Output enable for the data bus |
| pkt_end | input | 1 | Commits the partial packet of the selected FIFO |
| data_in | input | 16 | Inbound half of the data bus |
| data_out | output | 16 | Head word of the selected FIFO |
| data_oe | output | 16 | Per-bit tristate drive enable for `data_out` |
| empty | output | 4 | Per-FIFO empty flag |
| full | output | 4 | Per-FIFO full flag |
| pkt_avail | output | 4 | Per-FIFO committed-packet flag |
| conflict | output | 1 | Write and output enable asserted together |
| ovf_err | output | 1 | Sticky: a write hit a full FIFO |
| unf_err | output | 1 | Sticky: a read hit an empty FIFO |

## Verification
The bench holds an asynchronous write strobe high for several cycles. A design that treated it as a level would store several words instead of one, and one that missed the synchroniser would store none. It sets the width configurations to alternate across the FIFOs, so a port that applied the width of the wrong FIFO would return or drive the upper byte where it should stay zero. It issues strobes with chip select high, writes one word past full, and sends packet-end both with uncommitted words and on an empty FIFO. A wrong gate, a wrapped write pointer, or a commit that fires on nothing each shows up on the flags or in the data read back.

// File: rtl/slv_fifo_pkg.sv
package slv_fifo_pkg;

  typedef enum logic {
    XFER_SYNC  = 1'b0,
    XFER_ASYNC = 1'b1
  } xfer_mode_e;

  // One bundle for the three transfer controls, packed in a fixed lane order
  typedef struct packed {
    logic pend;
    logic rd;
    logic wr;
  } strobe_t;

  localparam int unsigned STROBE_BITS = $bits(strobe_t);

endpackage

// File: rtl/slv_strobe_sync.sv
module slv_strobe_sync #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] fall
);

  // two synchroniser stages, then a history stage for edge detection
  logic [N-1:0] meta_q, sync_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign fall = hist_q & ~sync_q;

endmodule

// File: rtl/slv_fifo_lane.sv
module slv_fifo_lane #(
  parameter int unsigned DW        = 16,
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned PKT_WORDS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          pend,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full,
  output logic          pkt_avail,
  output logic          drop_push,
  output logic          drop_pop
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned PW = $clog2(PKT_WORDS + 1);

  logic [DW-1:0] store [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] level_q, level_d;
  logic [PW-1:0] part_q, part_d;
  logic          avail_q;
  logic          push_ok, pop_ok, commit;

  assign empty   = (level_q == '0);
  assign full    = (level_q == CW'(DEPTH));
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign drop_push = push & full;
  assign drop_pop  = pop & empty;

  assign level_d = level_q + CW'(push_ok) - CW'(pop_ok);
  assign part_d  = part_q + PW'(push_ok);
  assign commit  = (part_d == PW'(PKT_WORDS)) | (pend & (part_d != '0));

  always_ff @(posedge clk) begin
    if (push_ok) store[wptr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
      part_q  <= '0;
      avail_q <= 1'b0;
    end else begin
      if (push_ok) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (pop_ok)  rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      level_q <= level_d;
      part_q  <= commit ? '0 : part_d;
      avail_q <= (commit | avail_q) & (level_d != '0);
    end
  end

  assign dout      = store[rptr_q];
  assign pkt_avail = avail_q;

endmodule

// File: rtl/slv_fifo_port.sv
module slv_fifo_port
  import slv_fifo_pkg::*;
#(
  parameter int unsigned NFIFO     = 4,
  parameter int unsigned DW        = 16,
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned PKT_WORDS = 4,
  localparam int unsigned SW       = $clog2(NFIFO),
  localparam int unsigned BW       = DW / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic [SW-1:0]    fifo_sel,
  input  logic             async_mode,
  input  logic [NFIFO-1:0] wide_cfg,
  input  logic             wr,
  input  logic             rd,
  input  logic             oe,
  input  logic             pkt_end,
  input  logic [DW-1:0]    data_in,
  output logic [DW-1:0]    data_out,
  output logic [DW-1:0]    data_oe,
  output logic [NFIFO-1:0] empty,
  output logic [NFIFO-1:0] full,
  output logic [NFIFO-1:0] pkt_avail,
  output logic             conflict,
  output logic             ovf_err,
  output logic             unf_err
);

  localparam logic [DW-1:0] LANE_WORD = {DW{1'b1}};
  localparam logic [DW-1:0] LANE_BYTE = {{(DW-BW){1'b0}}, {BW{1'b1}}};

  xfer_mode_e mode;
  strobe_t    gated, edge_ev, xfer;
  logic [STROBE_BITS-1:0] fall_vec;

  logic [DW-1:0]    head [NFIFO];
  logic [NFIFO-1:0] drop_w, drop_r;

  assign mode = xfer_mode_e'(async_mode);

  // chip select is applied before anything else sees the controls
  assign gated.wr   = ~sel_n & wr;
  assign gated.rd   = ~sel_n & rd;
  assign gated.pend = ~sel_n & pkt_end;

  slv_strobe_sync #(.N(STROBE_BITS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (gated),
    .fall  (fall_vec)
  );

  assign edge_ev = strobe_t'(fall_vec);
  assign xfer    = (mode == XFER_ASYNC) ? edge_ev : gated;

  for (genvar i = 0; i < NFIFO; i++) begin : g_lane
    logic          hit;
    logic [DW-1:0] wdata;

    assign hit   = (fifo_sel == SW'(i));
    assign wdata = wide_cfg[i] ? data_in : (data_in & LANE_BYTE);

    slv_fifo_lane #(
      .DW        (DW),
      .DEPTH     (DEPTH),
      .PKT_WORDS (PKT_WORDS)
    ) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (xfer.wr & hit),
      .pop       (xfer.rd & hit),
      .pend      (xfer.pend & hit),
      .din       (wdata),
      .dout      (head[i]),
      .empty     (empty[i]),
      .full      (full[i]),
      .pkt_avail (pkt_avail[i]),
      .drop_push (drop_w[i]),
      .drop_pop  (drop_r[i])
    );
  end

  assign data_out = head[fifo_sel];
  assign conflict = ~sel_n & oe & wr;

  always_comb begin
    data_oe = '0;
    if (~sel_n & oe & ~wr) data_oe = wide_cfg[fifo_sel] ? LANE_WORD : LANE_BYTE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_err <= 1'b0;
      unf_err <= 1'b0;
    end else begin
      ovf_err <= ovf_err | (|drop_w);
      unf_err <= unf_err | (|drop_r);
    end
  end

endmodule

// File: rtl/slv_fifo_port_chk.sv
module slv_fifo_port_chk #(
  parameter int unsigned NFIFO = 4,
  parameter int unsigned DW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_n,
  input logic             wr,
  input logic             oe,
  input logic [DW-1:0]    data_oe,
  input logic [NFIFO-1:0] empty,
  input logic [NFIFO-1:0] full,
  input logic [NFIFO-1:0] pkt_avail,
  input logic             conflict,
  input logic             ovf_err,
  input logic             unf_err
);

  localparam logic [DW-1:0] BYTE_EN = {{(DW/2){1'b0}}, {(DW/2){1'b1}}};

  assert_no_drive_unselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> (data_oe == '0));

  assert_lane_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe != '0) |-> ((data_oe == {DW{1'b1}}) || (data_oe == BYTE_EN)));

  assert_conflict_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && wr && oe) |-> (conflict && (data_oe == '0)));

  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((empty & full) == '0));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  assert_unf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unf_err |=> unf_err);

  assert_pkt_needs_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pkt_avail & empty) == '0));

endmodule

bind slv_fifo_port slv_fifo_port_chk #(.NFIFO(NFIFO), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_n     (sel_n),
  .wr        (wr),
  .oe        (oe),
  .data_oe   (data_oe),
  .empty     (empty),
  .full      (full),
  .pkt_avail (pkt_avail),
  .conflict  (conflict),
  .ovf_err   (ovf_err),
  .unf_err   (unf_err)
);

// File: tb/slv_fifo_port_bench.sv
`timescale 1ns/1ps
module slv_fifo_port_bench;

  localparam logic [3:0] CFG = 4'b0101;  // FIFO0,2 word; FIFO1,3 byte

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1;
  logic [1:0]  fifo_sel = '0;
  logic        async_mode = 1'b0;
  logic [3:0]  wide_cfg = CFG;
  logic        wr = 1'b0, rd = 1'b0, oe = 1'b0, pkt_end = 1'b0;
  logic [15:0] data_in = '0;
  logic [15:0] data_out, data_oe;
  logic [3:0]  empty, full, pkt_avail;
  logic        conflict, ovf_err, unf_err;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  slv_fifo_port u_slv_fifo_port (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .fifo_sel(fifo_sel),
    .async_mode(async_mode), .wide_cfg(wide_cfg), .wr(wr), .rd(rd), .oe(oe),
    .pkt_end(pkt_end), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .empty(empty), .full(full), .pkt_avail(pkt_avail), .conflict(conflict),
    .ovf_err(ovf_err), .unf_err(unf_err)
  );

  // {op(1=read), addr(2), wdata(16), expected read data(16)}
  localparam int NV = 10;
  localparam logic [34:0] VEC [NV] = '{
    {1'b0, 2'd0, 16'h1234, 16'h0000},
    {1'b0, 2'd1, 16'hABCD, 16'h0000},
    {1'b0, 2'd0, 16'h5678, 16'h0000},
    {1'b0, 2'd2, 16'h0F0F, 16'h0000},
    {1'b1, 2'd0, 16'h0000, 16'h1234},
    {1'b1, 2'd1, 16'h0000, 16'h00CD},
    {1'b0, 2'd3, 16'hBEEF, 16'h0000},
    {1'b1, 2'd0, 16'h0000, 16'h5678},
    {1'b1, 2'd2, 16'h0000, 16'h0F0F},
    {1'b1, 2'd3, 16'h0000, 16'h00EF}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sel_n = 1'b1; wr = 0; rd = 0; oe = 0; pkt_end = 0; async_mode = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    fifo_sel = a; data_in = d; sel_n = 1'b0; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; sel_n = 1'b1;
  endtask

  task automatic do_read(input logic [1:0] a, input logic [15:0] exp, input string req);
    logic [15:0] lane;
    @(negedge clk);
    fifo_sel = a; sel_n = 1'b0; oe = 1'b1;
    #1;
    lane = CFG[a] ? 16'hFFFF : 16'h00FF;
    chk(data_out == exp, req, 32'(data_out), 32'(exp));
    chk(data_oe == lane, "R4 lane", 32'(data_oe), 32'(lane));
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0; oe = 1'b0; sel_n = 1'b1;
  endtask

  task automatic do_pend(input logic [1:0] a);
    @(negedge clk);
    fifo_sel = a; sel_n = 1'b0; pkt_end = 1'b1;
    @(negedge clk);
    pkt_end = 1'b0; sel_n = 1'b1;
  endtask

  task automatic async_pulse(input bit is_wr, input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    fifo_sel = a; data_in = d; sel_n = 1'b0;
    if (is_wr) wr = 1'b1; else rd = 1'b1;
    repeat (3) @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    repeat (4) @(negedge clk);
    sel_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(empty == 4'hF, "R1 empty", 32'(empty), 32'hF);
    chk(full == 4'h0, "R1 full", 32'(full), 0);
    chk(pkt_avail == 4'h0, "R1 pkt_avail", 32'(pkt_avail), 0);
    chk({ovf_err, unf_err} == 2'b00, "R1 errors", 32'({ovf_err, unf_err}), 0);
    chk(data_oe == 16'h0, "R1 data_oe", 32'(data_oe), 0);

    // R2 / R4 vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][34]) do_read(VEC[i][33:32], VEC[i][15:0], "R2 fifo order");
      else            do_write(VEC[i][33:32], VEC[i][31:16]);
    end
    #1 chk(empty == 4'hF, "R2 drained", 32'(empty), 32'hF);

    // R3 chip select gating
    do_reset();
    @(negedge clk);
    fifo_sel = 2'd0; sel_n = 1'b1; wr = 1'b1; oe = 1'b1; pkt_end = 1'b1; data_in = 16'h7777;
    #1 chk(data_oe == 16'h0, "R3 oe gated", 32'(data_oe), 0);
    repeat (2) @(negedge clk);
    wr = 1'b0; rd = 1'b1;
    repeat (2) @(negedge clk);
    rd = 1'b0; oe = 1'b0; pkt_end = 1'b0;
    #1;
    chk(empty[0] == 1'b1, "R3 no write", 32'(empty), 32'hF);
    chk(unf_err == 1'b0, "R3 no read", 32'(unf_err), 0);
    chk(pkt_avail == 4'h0, "R3 no commit", 32'(pkt_avail), 0);

    // R5 synchronous qualifier: three cycles held, three words
    @(negedge clk);
    fifo_sel = 2'd0; sel_n = 1'b0; wr = 1'b1; data_in = 16'h1111;
    @(negedge clk) data_in = 16'h2222;
    @(negedge clk) data_in = 16'h3333;
    @(negedge clk) begin wr = 1'b0; sel_n = 1'b1; end
    do_read(2'd0, 16'h1111, "R5 word1");
    do_read(2'd0, 16'h2222, "R5 word2");
    do_read(2'd0, 16'h3333, "R5 word3");
    #1 chk(empty[0] == 1'b1, "R5 count", 32'(empty[0]), 1);

    // R6 asynchronous strobes: one transfer per falling edge
    do_reset();
    async_mode = 1'b1;
    async_pulse(1'b1, 2'd0, 16'hA1A1);
    async_pulse(1'b1, 2'd0, 16'hB2B2);
    async_pulse(1'b0, 2'd0, 16'h0000);
    async_mode = 1'b0;
    do_read(2'd0, 16'hB2B2, "R6 single transfer");
    #1 chk(empty[0] == 1'b1, "R6 exact count", 32'(empty[0]), 1);

    // R7 bus conflict
    @(negedge clk);
    fifo_sel = 2'd3; sel_n = 1'b0; wr = 1'b1; oe = 1'b1; data_in = 16'h0042;
    #1;
    chk(conflict == 1'b1, "R7 conflict", 32'(conflict), 1);
    chk(data_oe == 16'h0, "R7 released", 32'(data_oe), 0);
    @(negedge clk);
    wr = 1'b0; oe = 1'b0; sel_n = 1'b1;
    #1 chk(conflict == 1'b0, "R7 clear", 32'(conflict), 0);

    // R8 overflow
    do_reset();
    for (int k = 0; k < 8; k++) do_write(2'd1, 16'(k + 16'h10));
    #1 chk(full[1] == 1'b1, "R8 full", 32'(full), 32'h2);
    chk(ovf_err == 1'b0, "R8 no early error", 32'(ovf_err), 0);
    do_write(2'd1, 16'h00FF);
    #1 chk(ovf_err == 1'b1, "R8 ovf_err", 32'(ovf_err), 1);
    do_read(2'd1, 16'h0010, "R8 head kept");
    for (int k = 1; k < 8; k++) do_read(2'd1, 16'(k + 16'h10), "R8 data kept");
    #1 chk(empty[1] == 1'b1, "R8 dropped word absent", 32'(empty[1]), 1);

    // R9 underflow
    do_reset();
    @(negedge clk);
    fifo_sel = 2'd3; sel_n = 1'b0; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0; sel_n = 1'b1;
    #1;
    chk(unf_err == 1'b1, "R9 unf_err", 32'(unf_err), 1);
    chk(empty[3] == 1'b1, "R9 still empty", 32'(empty[3]), 1);
    do_write(2'd3, 16'h0055);
    do_read(2'd3, 16'h0055, "R9 fifo intact");

    // R10 packet commit
    do_reset();
    do_write(2'd2, 16'hC001);
    do_write(2'd2, 16'hC002);
    #1 chk(pkt_avail[2] == 1'b0, "R10 partial", 32'(pkt_avail), 0);
    do_pend(2'd2);
    #1 chk(pkt_avail[2] == 1'b1, "R10 pkt_end commit", 32'(pkt_avail), 32'h4);
    for (int k = 0; k < 4; k++) do_write(2'd0, 16'(16'hD000 + k));
    #1 chk(pkt_avail[0] == 1'b1, "R10 full packet", 32'(pkt_avail), 32'h5);
    do_pend(2'd3);
    #1 chk(pkt_avail[3] == 1'b0, "R10 empty pend", 32'(pkt_avail), 32'h5);
    do_read(2'd2, 16'hC001, "R10 read");
    do_read(2'd2, 16'hC002, "R10 read");
    #1 chk(pkt_avail[2] == 1'b0, "R10 cleared", 32'(pkt_avail), 32'h1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule